// File: doc/BRIEF.md
# Memory Operation Admission and Ordering Dispatcher

This block sits at the dispatch stage of an out-of-order core, in front of a memory dependency group tracker. Each cycle it is offered at most one operation, described by three flags: whether it may read memory, whether it may write memory, and whether it has side effects the scheduler cannot model. The block checks whether the load queue and the store queue have room and returns a two-bit admission status. When the operation is accepted, it assigns the operation a dependency group number and, in the same cycle, issues link requests to the tracker. Each link names an earlier group and says whether the dependency is a data dependency or only an ordering dependency.

The ordering model is weak. Reads may overtake reads. Writes never overtake older writes or older reads. Reads overtake writes only when a configuration bit declares that reads and writes never alias. Operations with side effects act as barriers: a read-side barrier holds back later reads, a write-side barrier holds back later writes, and an operation with both sides holds back both. Every read, write and barrier occupies one queue entry. A read entry is released by a retire pulse and a write entry by a commit pulse.

Top module: `lsq_dispatch`

## Requirements
- R1: `op_status` is 0 when the operation can be accepted, 1 when it needs a load-queue entry and the load queue is full, and 2 when it needs a store-queue entry and the store queue is full. The load check takes precedence. An operation with neither the read flag nor the write flag is non-memory: it always gets status 0, is always ready, gets group 0 and emits no links.
- R2: A queue whose size parameter is 0 is unbounded and never reports full. Otherwise a queue is full exactly when its occupancy equals its size.
- R3: Every accepted operation with the read flag takes one load-queue entry, and every accepted operation with the write flag takes one store-queue entry. This includes barriers. `ld_retire` frees one load entry and `st_commit` frees one store entry. A release against an empty queue has no effect. An allocation and a release in the same cycle leave the occupancy unchanged.
- R4: Links appear on four channels, each with a valid bit, a data bit (1 = data, 0 = order) and a group field. Channel 0 carries the latest read group, channel 1 the latest read-barrier group, channel 2 the latest write group and channel 3 the latest write-barrier group. A write always takes an order link on channel 0 to the latest read group and on channel 2 to the latest write group, whatever the alias setting. Channel 0 is dropped when it would name the same group that channel 2 already names.
- R5: A read with `cfg_no_alias` = 0 takes a data link on channel 2 to the latest write group. With `cfg_no_alias` = 1, a read without the write flag takes no channel-2 link. An operation with both flags uses the data kind on channel 2 when aliasing is assumed.
- R6: A plain read (read flag only) that arrives while a read group is open joins that group: it gets the same group number and emits no links. A plain read that starts a new group opens it. Any accepted write or barrier closes it.
- R7: Every operation with the read flag takes a data link on channel 1 to the latest read-barrier group. Every operation with the write flag takes a data link on channel 3 to the latest write-barrier group. Channel 3 is dropped when channel 1 already names the same group.
- R8: A read-side barrier also takes an order link on channel 0 to the latest read group. The write side of a barrier is covered by R4.
- R9: `op_ready` is 1 exactly when the status is 0 and at least one of the following holds: the operation is non-memory, it joins an open read group, or `grp_avail` is 1. New groups are numbered 1, 2, … up to 2^GID_W−1, and numbering then wraps back to 1, never 0.
- R10: After reset all four latest-group registers hold 0, which means none, and no read group is open. Links are emitted only for nonzero groups, so the first memory operation emits none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is offered this cycle |
| op_may_load | input | 1 | Operation reads memory |
| op_may_store | input | 1 | Operation writes memory |
| op_side_eff | input | 1 | Operation has unmodelled side effects (barrier) |
| cfg_no_alias | input | 1 | Reads are assumed never to alias writes |
| grp_avail | input | 1 | Group tracker can accept a new group |
| ld_retire | input | 1 | Free one load-queue entry |
| st_commit | input | 1 | Free one store-queue entry |
| op_ready | output | 1 | Operation is accepted when valid |
| op_status | output | 2 | Admission status: 0 ok, 1 load queue full, 2 store queue full |
| op_grp | output | GID_W | Group assigned to the operation |
| lnk_valid | output | 4 | Per-channel link request, qualified by acceptance |
| lnk_data | output | 4 | Per-channel link kind, 1 = data, 0 = order |
| lnk_grp | output | 4*GID_W | Per-channel predecessor group, channel 0 in the low bits |

## Verification
Status, ready, group number and all link fields are combinational functions of the inputs and the registered state. They are due in the same cycle the operation is offered. The bench therefore drives inputs just after a falling edge and samples one nanosecond later, well before the next rising edge. Queue occupancy, the latest-group registers, the open-group flag and the next group number all change on the rising edge that accepts an operation or a release pulse. Each of these effects is observed only through the outputs of the following offer. The bench keeps its own model of that state from the requirements and advances it only after that edge.

// File: rtl/lsq_pkg.sv
`timescale 1ns/1ps
package lsq_pkg;

    typedef enum logic [1:0] {
        ADM_OK      = 2'd0,
        ADM_LQ_FULL = 2'd1,
        ADM_SQ_FULL = 2'd2
    } adm_status_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic fx;
    } mem_op_t;

    localparam int LNK_N   = 4;
    localparam int LNK_RD  = 0;
    localparam int LNK_RDB = 1;
    localparam int LNK_WR  = 2;
    localparam int LNK_WRB = 3;

    function automatic logic is_mem(mem_op_t op);
        return op.rd | op.wr;
    endfunction

    function automatic logic is_plain_rd(mem_op_t op);
        return op.rd & ~op.wr & ~op.fx;
    endfunction

endpackage

// File: rtl/lsq_occupancy.sv
`timescale 1ns/1ps
module lsq_occupancy #(
    parameter int SIZE  = 4,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc,
    input  logic             free_one,
    output logic             full,
    output logic [CNT_W-1:0] used
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             dec;

    assign dec  = free_one && (cnt_q != '0);
    assign used = cnt_q;

    generate
        if (SIZE == 0) begin : g_unbounded
            assign full = 1'b0;
        end else begin : g_bounded
            assign full = (cnt_q == CNT_W'(SIZE));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (alloc && !dec && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (dec && !alloc) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/lsq_group_ctx.sv
`timescale 1ns/1ps
module lsq_group_ctx
    import lsq_pkg::*;
#(
    parameter int GID_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  mem_op_t          op,
    input  logic             join_grp,
    input  logic [GID_W-1:0] grp,
    output logic [GID_W-1:0] last_rd,
    output logic [GID_W-1:0] last_rdb,
    output logic [GID_W-1:0] last_wr,
    output logic [GID_W-1:0] last_wrb,
    output logic             rd_open,
    output logic [GID_W-1:0] next_id
);
    localparam logic [GID_W-1:0] ID_MAX = {GID_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            last_rd  <= '0;
            last_rdb <= '0;
            last_wr  <= '0;
            last_wrb <= '0;
            rd_open  <= 1'b0;
            next_id  <= GID_W'(1);
        end else if (accept && is_mem(op)) begin
            if (!join_grp) begin
                next_id <= (next_id == ID_MAX) ? GID_W'(1) : next_id + 1'b1;
            end
            if (is_plain_rd(op)) begin
                last_rd <= grp;
                rd_open <= 1'b1;
            end else begin
                rd_open <= 1'b0;
                if (op.fx) begin
                    if (op.rd) last_rdb <= grp;
                    if (op.wr) last_wrb <= grp;
                end else begin
                    if (op.rd) last_rd <= grp;
                    if (op.wr) last_wr <= grp;
                end
            end
        end
    end
endmodule

// File: rtl/lsq_link_gen.sv
`timescale 1ns/1ps
module lsq_link_gen
    import lsq_pkg::*;
#(
    parameter int GID_W = 4
) (
    input  logic                   emit,
    input  mem_op_t                op,
    input  logic                   no_alias,
    input  logic [GID_W-1:0]       last_rd,
    input  logic [GID_W-1:0]       last_rdb,
    input  logic [GID_W-1:0]       last_wr,
    input  logic [GID_W-1:0]       last_wrb,
    output logic [LNK_N-1:0]       v,
    output logic [LNK_N-1:0]       d,
    output logic [LNK_N*GID_W-1:0] g
);
    logic wr_v, rd_v, rdb_v, wrb_v;
    logic rd_uses_wr;

    always_comb begin
        rd_uses_wr = op.rd && !no_alias;
        wr_v  = (last_wr != '0) && (op.wr || rd_uses_wr);
        rd_v  = (last_rd != '0) && (op.wr || (op.rd && op.fx))
                && !(wr_v && last_rd == last_wr);
        rdb_v = op.rd && (last_rdb != '0);
        wrb_v = op.wr && (last_wrb != '0) && !(rdb_v && last_rdb == last_wrb);

        v = '0;
        if (emit) begin
            v[LNK_RD]  = rd_v;
            v[LNK_RDB] = rdb_v;
            v[LNK_WR]  = wr_v;
            v[LNK_WRB] = wrb_v;
        end
        d          = '0;
        d[LNK_RDB] = 1'b1;
        d[LNK_WR]  = rd_uses_wr;
        d[LNK_WRB] = 1'b1;
        g = {last_wrb, last_wr, last_rdb, last_rd};
    end
endmodule

// File: rtl/lsq_dispatch.sv
`timescale 1ns/1ps
module lsq_dispatch
    import lsq_pkg::*;
#(
    parameter int LQ_SIZE = 4,
    parameter int SQ_SIZE = 3,
    parameter int CNT_W   = 4,
    parameter int GID_W   = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   op_valid,
    input  logic                   op_may_load,
    input  logic                   op_may_store,
    input  logic                   op_side_eff,
    input  logic                   cfg_no_alias,
    input  logic                   grp_avail,
    input  logic                   ld_retire,
    input  logic                   st_commit,
    output logic                   op_ready,
    output logic [1:0]             op_status,
    output logic [GID_W-1:0]       op_grp,
    output logic [LNK_N-1:0]       lnk_valid,
    output logic [LNK_N-1:0]       lnk_data,
    output logic [LNK_N*GID_W-1:0] lnk_grp
);
    mem_op_t          op;
    adm_status_e      status;
    logic             lq_full, sq_full;
    logic [CNT_W-1:0] lq_used, sq_used;
    logic [GID_W-1:0] last_rd, last_rdb, last_wr, last_wrb, next_id;
    logic             rd_open, join_grp, accept;

    assign op = '{rd: op_may_load, wr: op_may_store, fx: op_side_eff};

    always_comb begin
        status = ADM_OK;
        if (op.rd && lq_full)      status = ADM_LQ_FULL;
        else if (op.wr && sq_full) status = ADM_SQ_FULL;
    end

    assign join_grp  = is_plain_rd(op) && rd_open && (last_rd != '0);
    assign op_status = status;
    assign op_ready  = (status == ADM_OK) && (!is_mem(op) || join_grp || grp_avail);
    assign accept    = op_valid && op_ready;
    assign op_grp    = !is_mem(op) ? '0 : (join_grp ? last_rd : next_id);

    lsq_occupancy #(.SIZE(LQ_SIZE), .CNT_W(CNT_W)) u_lq (
        .clk(clk), .rst(rst), .alloc(accept && op.rd), .free_one(ld_retire),
        .full(lq_full), .used(lq_used)
    );

    lsq_occupancy #(.SIZE(SQ_SIZE), .CNT_W(CNT_W)) u_sq (
        .clk(clk), .rst(rst), .alloc(accept && op.wr), .free_one(st_commit),
        .full(sq_full), .used(sq_used)
    );

    lsq_group_ctx #(.GID_W(GID_W)) u_ctx (
        .clk(clk), .rst(rst), .accept(accept), .op(op), .join_grp(join_grp),
        .grp(op_grp), .last_rd(last_rd), .last_rdb(last_rdb), .last_wr(last_wr),
        .last_wrb(last_wrb), .rd_open(rd_open), .next_id(next_id)
    );

    lsq_link_gen #(.GID_W(GID_W)) u_lnk (
        .emit(accept && is_mem(op) && !join_grp), .op(op), .no_alias(cfg_no_alias),
        .last_rd(last_rd), .last_rdb(last_rdb), .last_wr(last_wr), .last_wrb(last_wrb),
        .v(lnk_valid), .d(lnk_data), .g(lnk_grp)
    );
endmodule

// File: rtl/lsq_dispatch_chk.sv
`timescale 1ns/1ps
module lsq_dispatch_chk #(
    parameter int LQ_SIZE = 4,
    parameter int SQ_SIZE = 3,
    parameter int CNT_W   = 4,
    parameter int GID_W   = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             op_valid,
    input logic             op_may_load,
    input logic             op_may_store,
    input logic             op_side_eff,
    input logic             op_ready,
    input logic [1:0]       op_status,
    input logic [GID_W-1:0] op_grp,
    input logic [3:0]       lnk_valid,
    input logic [3:0]       lnk_data,
    input logic [CNT_W-1:0] lq_used,
    input logic [CNT_W-1:0] sq_used,
    input logic             rd_open
);
    logic acc, mem;
    assign acc = op_valid && op_ready;
    assign mem = op_may_load || op_may_store;

    p_busy_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        (op_status != 2'd0) |-> !op_ready);

    p_grp_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
        (acc && mem) |-> (op_grp != '0));

    p_nomem_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (acc && !mem) |-> (lnk_valid == 4'd0));

    p_lq_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (LQ_SIZE == 0) || (lq_used <= CNT_W'(LQ_SIZE)));

    p_sq_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (SQ_SIZE == 0) || (sq_used <= CNT_W'(SQ_SIZE)));

    p_wr_wr_order_r4: assert property (@(posedge clk) disable iff (rst)
        (acc && op_may_store && !op_may_load && lnk_valid[2]) |-> !lnk_data[2]);

    p_store_closes_r6: assert property (@(posedge clk) disable iff (rst)
        (acc && op_may_store) |=> !rd_open);

    p_barrier_data_r7: assert property (@(posedge clk) disable iff (rst)
        (lnk_valid[1] || lnk_valid[3]) |-> (lnk_data[1] && lnk_data[3]));
endmodule

bind lsq_dispatch lsq_dispatch_chk #(
    .LQ_SIZE(LQ_SIZE), .SQ_SIZE(SQ_SIZE), .CNT_W(CNT_W), .GID_W(GID_W)
) u_chk (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_may_load(op_may_load),
    .op_may_store(op_may_store), .op_side_eff(op_side_eff), .op_ready(op_ready),
    .op_status(op_status), .op_grp(op_grp), .lnk_valid(lnk_valid),
    .lnk_data(lnk_data), .lq_used(lq_used), .sq_used(sq_used), .rd_open(rd_open)
);

// File: tb/tb_lsq_dispatch.sv
`timescale 1ns/1ps
module tb_lsq_dispatch;
    localparam int LQS = 4;
    localparam int SQS = 3;
    localparam int GW  = 4;

    logic clk = 1'b0;
    logic rst;
    logic op_valid, op_may_load, op_may_store, op_side_eff, cfg_no_alias;
    logic grp_avail, ld_retire, st_commit;
    logic op_ready;
    logic [1:0] op_status;
    logic [GW-1:0] op_grp;
    logic [3:0] lnk_valid, lnk_data;
    logic [4*GW-1:0] lnk_grp;
    logic u_ready;
    logic [1:0] u_status;
    logic [GW-1:0] u_grp;
    logic [3:0] u_v, u_d;
    logic [4*GW-1:0] u_g;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    lsq_dispatch #(.LQ_SIZE(LQS), .SQ_SIZE(SQS), .CNT_W(4), .GID_W(GW)) dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_may_load(op_may_load),
        .op_may_store(op_may_store), .op_side_eff(op_side_eff),
        .cfg_no_alias(cfg_no_alias), .grp_avail(grp_avail), .ld_retire(ld_retire),
        .st_commit(st_commit), .op_ready(op_ready), .op_status(op_status),
        .op_grp(op_grp), .lnk_valid(lnk_valid), .lnk_data(lnk_data), .lnk_grp(lnk_grp)
    );

    lsq_dispatch #(.LQ_SIZE(0), .SQ_SIZE(0), .CNT_W(4), .GID_W(GW)) dut_unb (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_may_load(op_may_load),
        .op_may_store(op_may_store), .op_side_eff(op_side_eff),
        .cfg_no_alias(cfg_no_alias), .grp_avail(grp_avail), .ld_retire(ld_retire),
        .st_commit(st_commit), .op_ready(u_ready), .op_status(u_status),
        .op_grp(u_grp), .lnk_valid(u_v), .lnk_data(u_d), .lnk_grp(u_g)
    );

    // bench model of the architectural state
    int m_lq, m_sq;
    logic [GW-1:0] m_rd, m_rdb, m_wr, m_wrb, m_next;
    logic m_open;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_lq = 0; m_sq = 0; m_rd = '0; m_rdb = '0; m_wr = '0; m_wrb = '0;
        m_next = GW'(1); m_open = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; op_valid = 0; op_may_load = 0; op_may_store = 0; op_side_eff = 0;
        cfg_no_alias = 0; grp_avail = 1; ld_retire = 0; st_commit = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic step(input logic ld, input logic st, input logic se, input logic vld,
                        input logic ret, input logic com, input logic av, input logic na);
        logic mem, share, erdy, fire, wv, rv, rbv, sbv, rd_wr;
        int est;
        logic [GW-1:0] egrp;
        logic [3:0] ev, ed;
        logic [GW-1:0] eg [4];
        @(negedge clk);
        op_valid = vld; op_may_load = ld; op_may_store = st; op_side_eff = se;
        ld_retire = ret; st_commit = com; grp_avail = av; cfg_no_alias = na;
        #1;
        mem = ld | st;
        est = 0;
        if (ld && m_lq == LQS) est = 1;
        else if (st && m_sq == SQS) est = 2;
        share = ld && !st && !se && m_open && (m_rd != 0);
        erdy = (est == 0) && (!mem || share || av);
        egrp = !mem ? '0 : (share ? m_rd : m_next);
        fire = vld && erdy;
        rd_wr = ld && !na;
        wv  = (m_wr != 0) && (st || rd_wr);
        rv  = (m_rd != 0) && (st || (ld && se)) && !(wv && m_rd == m_wr);
        rbv = ld && (m_rdb != 0);
        sbv = st && (m_wrb != 0) && !(rbv && m_rdb == m_wrb);
        ev = (fire && mem && !share) ? {sbv, wv, rbv, rv} : 4'b0;
        ed = {1'b1, rd_wr, 1'b1, 1'b0};
        eg[0] = m_rd; eg[1] = m_rdb; eg[2] = m_wr; eg[3] = m_wrb;

        chk(op_status == 2'(est), "R1 R2 R3 status", int'(op_status), est);
        chk(op_ready == erdy, "R9 ready", int'(op_ready), int'(erdy));
        if (ld) chk(u_status == 2'd0, "R2 unbounded status", int'(u_status), 0);
        if (fire) chk(op_grp == egrp, "R6 R9 group", int'(op_grp), int'(egrp));
        for (int c = 0; c < 4; c++) begin
            // channel 0: R4/R8, channel 1: R7, channel 2: R4/R5, channel 3: R7
            chk(lnk_valid[c] == ev[c], "R4 R5 R7 R8 link valid", c * 10 + int'(lnk_valid[c]), c * 10 + int'(ev[c]));
            if (ev[c]) begin
                chk(lnk_data[c] == ed[c], "R4 R5 R7 link kind", c * 10 + int'(lnk_data[c]), c * 10 + int'(ed[c]));
                chk(lnk_grp[c*GW +: GW] == eg[c], "R4 R7 R8 link group", int'(lnk_grp[c*GW +: GW]), int'(eg[c]));
            end
        end

        @(posedge clk);
        if (fire && ld && !(ret && m_lq != 0)) m_lq++;
        else if (!(fire && ld) && ret && m_lq != 0) m_lq--;
        if (fire && st && !(com && m_sq != 0)) m_sq++;
        else if (!(fire && st) && com && m_sq != 0) m_sq--;
        if (fire && mem) begin
            if (!share) m_next = (m_next == '1) ? GW'(1) : m_next + 1'b1;
            if (ld && !st && !se) begin
                m_rd = egrp; m_open = 1'b1;
            end else begin
                m_open = 1'b0;
                if (se) begin
                    if (ld) m_rdb = egrp;
                    if (st) m_wrb = egrp;
                end else begin
                    if (ld) m_rd = egrp;
                    if (st) m_wr = egrp;
                end
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run finished)");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        do_reset();
        // R10: first operation after reset emits no links and gets group 1
        step(1, 1, 0, 1, 0, 0, 1, 0);
        chk(m_next == GW'(2), "R10 first group", int'(m_next), 2);
        // R6: loads share a group, a store breaks it; R5 data link with aliasing
        step(1, 0, 0, 1, 0, 0, 1, 0);
        step(1, 0, 0, 1, 0, 0, 0, 0);
        step(0, 1, 0, 1, 0, 0, 1, 0);
        step(1, 0, 0, 1, 0, 0, 1, 1);
        // R2: fill the load queue (size 4) and see status 1, then free an entry
        step(1, 0, 0, 1, 0, 0, 1, 0);
        step(1, 0, 0, 1, 0, 0, 1, 0);
        step(0, 0, 0, 1, 1, 0, 1, 0);
        step(1, 0, 0, 1, 0, 0, 1, 0);
        // R3: store queue fills at 3, commit frees it
        step(0, 1, 0, 1, 0, 0, 1, 0);
        step(0, 1, 1, 1, 0, 0, 1, 0);
        step(0, 1, 0, 1, 0, 1, 1, 0);
        // R7/R8 barriers
        do_reset();
        step(1, 0, 0, 1, 0, 0, 1, 0);
        step(1, 0, 1, 1, 0, 0, 1, 0);
        step(1, 0, 0, 1, 1, 0, 1, 0);
        step(1, 1, 1, 1, 1, 0, 1, 0);
        step(1, 1, 0, 1, 1, 1, 1, 0);
        step(0, 1, 0, 1, 1, 1, 1, 0);
        // R1: non-memory operation
        step(0, 0, 1, 1, 1, 1, 0, 0);
        // sweep over every operation kind with varying releases and group space
        lf = 16'hACE1;
        for (int i = 0; i < 1500; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[0], lf[1], lf[2] & lf[3], lf[4] | lf[5], lf[6], lf[7],
                 lf[8] | lf[9], i[6]);
            if (i == 700) do_reset();
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule